// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

The block holds three independent 16-bit down-counters behind a byte-wide register bus. All three advance on one shared tick-enable input, nominally a 1193182 Hz strobe. Software picks a channel's counting mode and byte-access pattern by writing a control word. It loads a count through the channel's data port, one or two bytes at a time. It reads the count back the same way, either live or from a snapshot taken by a latch command. Every channel drives an output pin, and channel 0's pin is also the interrupt request. A separate speaker register, selected by its own strobe, enables channel 2's ticks and reports channel 2's output.

Each channel is a run-state machine with four named states. IDLE means stopped. PEND means a count has been written and waits for a tick. ACTIVE means counting. DONE covers the single tick after a strobe pulse. The transitions are: IDLE to PEND on a count commit; PEND to ACTIVE on a tick, which loads the counter; ACTIVE to DONE at terminal count in strobe mode; DONE to IDLE on the next tick; and any state to IDLE on a non-latch control word. A second machine, the access sequencer, has the states NONE, LO and HI. It selects which reload byte the next data write fills. A read toggle picks which byte the next data read returns.

Top module: `pit_timer`

## Requirements
- R1: After reset every channel is IDLE with counter and reload zero, no pending latch, reads starting on the low byte, all output pins and `irq` low, the access sequencer in NONE, and the speaker register zero.
- R2: A write to data port 3 is a control word. Its fields are: bits [7:6] select the channel, bits [5:4] give the access code, and bits [3:1] give the mode. Mode codes 6 and 7 act as 2 and 3. Mode 5 acts as 4. A channel field of 3 is ignored. A non-latch control word stores the mode and access code and stops the channel (IDLE). It resets the read toggle to the low byte and sets the output low for modes 0 and 1, and high otherwise.
- R3: Access code 0 is a latch command. It copies the live counter into a holding register when no latch is pending. A latch command while a latch is pending changes nothing.
- R4: Data reads of ports 0 to 2 alternate low byte and high byte, starting with the low byte. They return the latched value while a latch is pending, and the live counter otherwise. Reading the high byte releases the latch. A read of port 3 returns 0.
- R5: Access code 1 writes the reload low byte and commits. Code 2 writes the high byte and commits. Code 3 writes the low byte, then the high byte, commits after the high byte, and then expects a low byte again. A byte that is not written keeps its value. Data writes before any control word are ignored.
- R6: A commit moves the channel to PEND, except for a mode-2 channel that is ACTIVE. That channel keeps counting and takes up the new reload value at its next terminal count.
- R7: On the first tick in PEND the counter loads the reload value, with bit 0 cleared in mode 3, and the channel becomes ACTIVE. Counters change only on ticks. A count of 0 stands for 65536.
- R8: Modes 0 and 1: a commit drives the output low. At terminal count (the tick that takes the counter to zero) the output goes high and stays high, and the counter reloads and keeps running.
- R9: Mode 2: at each terminal count the counter reloads and the output goes low until the next tick.
- R10: Mode 3: the counter steps by 2 per tick, the output toggles at each terminal count, and the reload is made even at each wrap.
- R11: Mode 4: at terminal count the counter reloads and the output goes low for one tick. The channel then stops, with the counter frozen, until a new count is committed.
- R12: Speaker register bit 0 enables channel 2's ticks. A speaker read returns the stored value with bit 5 replaced by channel 2's output while bit 0 is set, and by 0 otherwise. A speaker write stores every bit except bit 5, which is stored as 0.
- R13: `irq` follows channel 0's output pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Shared count-tick enable |
| bus_addr | input | 2 | Port select: 0-2 channel data, 3 control |
| bus_spk | input | 1 | Selects the speaker register instead of bus_addr |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; advances read state at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| tmr_out | output | 3 | Channel output pins |
| irq | output | 1 | Interrupt request (channel 0 output) |

## Verification
Every cycle, the assertions check the following. A pending channel loads and turns active on its tick. A square-wave counter stays even. A pending latch holds until its high byte is read. A mode-0/1 output never falls while counting. A stopped counter does not move. The speaker register never holds bit 5. The bench's scenarios are needed for the rest: exact counter values and output levels after a given number of ticks, byte ordering on reads and writes, the mid-count rewrite of a rate generator, speaker gating, and the control-word aliases.

// File: rtl/pit_pkg.sv
package pit_pkg;

    typedef enum logic [1:0] {RUN_IDLE, RUN_PEND, RUN_ACTIVE, RUN_DONE} run_e;
    typedef enum logic [1:0] {ACC_NONE, ACC_LO, ACC_HI} acc_e;
    typedef enum logic [1:0] {AM_LATCH, AM_LO, AM_HI, AM_LOHI} amode_e;
    typedef enum logic [2:0] {
        OM_TERM, OM_ONESHOT, OM_RATE, OM_SQUARE, OM_SWSTB, OM_HWSTB
    } omode_e;

    function automatic omode_e norm_mode(input logic [2:0] m);
        case (m)
            3'd5:    return OM_SWSTB;
            3'd6:    return OM_RATE;
            3'd7:    return OM_SQUARE;
            default: return omode_e'(m);
        endcase
    endfunction

endpackage

// File: rtl/pit_bus_decode.sv
module pit_bus_decode #(
    parameter int N_CH   = 3,
    parameter int BUS_W  = 8,
    parameter int ADDR_W = 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              spk_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [BUS_W-1:0]  wdata_i,
    output logic [N_CH-1:0]   data_wr_o,
    output logic [N_CH-1:0]   data_rd_o,
    output logic [N_CH-1:0]   cmd_wr_o,
    output logic              spk_wr_o
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(N_CH);
    localparam int SEL_LSB = BUS_W - 2;

    logic ctrl_wr;
    assign ctrl_wr  = wr_i && !spk_i && (addr_i == CTRL_ADDR);
    assign spk_wr_o = wr_i && spk_i;

    for (genvar i = 0; i < N_CH; i++) begin : g_dec
        assign data_wr_o[i] = wr_i && !spk_i && (addr_i == ADDR_W'(i));
        assign data_rd_o[i] = rd_i && !spk_i && (addr_i == ADDR_W'(i));
        assign cmd_wr_o[i]  = ctrl_wr && (wdata_i[BUS_W-1:SEL_LSB] == 2'(i));
    end

endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             cmd_i,
    input  logic [1:0]       cmd_acc_i,
    input  logic [2:0]       cmd_mode_i,
    input  logic             wr_i,
    input  logic             rd_i,
    input  logic [BUS_W-1:0] wdata_i,
    output logic [BUS_W-1:0] rdata_o,
    output logic             out_o
);
    localparam int CNT_W = 2 * BUS_W;

    run_e             run_q, run_d;
    acc_e             acc_q, acc_d;
    amode_e           am_q, am_d;
    omode_e           om_q, om_d;
    logic [CNT_W-1:0] reload_q, reload_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] lat_q, lat_d;
    logic             lat_v_q, lat_v_d;
    logic             rd_hi_q, rd_hi_d;
    logic             out_q, out_d;

    logic             is_sq, is_rate, is_level;
    logic [CNT_W-1:0] step, reload_eff, rd_src;
    logic             tc, commit;
    omode_e           new_mode;

    assign is_sq      = (om_q == OM_SQUARE);
    assign is_rate    = (om_q == OM_RATE);
    assign is_level   = (om_q == OM_TERM) || (om_q == OM_ONESHOT);
    assign step       = is_sq ? CNT_W'(2) : CNT_W'(1);
    assign reload_eff = is_sq ? {reload_q[CNT_W-1:1], 1'b0} : reload_q;
    assign tc         = (cnt_q == step);
    assign new_mode   = norm_mode(cmd_mode_i);

    // next-state process
    always_comb begin
        run_d    = run_q;
        acc_d    = acc_q;
        am_d     = am_q;
        om_d     = om_q;
        reload_d = reload_q;
        cnt_d    = cnt_q;
        lat_d    = lat_q;
        lat_v_d  = lat_v_q;
        rd_hi_d  = rd_hi_q;
        out_d    = out_q;
        commit   = 1'b0;

        if (tick_i) begin
            unique case (run_q)
                RUN_IDLE: ;
                RUN_PEND: begin
                    cnt_d = reload_eff;
                    run_d = RUN_ACTIVE;
                end
                RUN_ACTIVE: begin
                    if (tc) begin
                        cnt_d = reload_eff;
                        unique case (om_q)
                            OM_TERM, OM_ONESHOT: out_d = 1'b1;
                            OM_RATE:             out_d = 1'b0;
                            OM_SQUARE:           out_d = ~out_q;
                            OM_SWSTB, OM_HWSTB: begin
                                out_d = 1'b0;
                                run_d = RUN_DONE;
                            end
                            default: ;
                        endcase
                    end else begin
                        cnt_d = cnt_q - step;
                        if (is_rate) out_d = 1'b1;
                    end
                end
                RUN_DONE: begin
                    out_d = 1'b1;
                    run_d = RUN_IDLE;
                end
                default: ;
            endcase
        end

        if (rd_i) begin
            rd_hi_d = ~rd_hi_q;
            if (rd_hi_q) lat_v_d = 1'b0;
        end

        if (wr_i) begin
            unique case (acc_q)
                ACC_NONE: ;
                ACC_LO: begin
                    reload_d[BUS_W-1:0] = wdata_i;
                    if (am_q == AM_LOHI) acc_d = ACC_HI;
                    else                 commit = 1'b1;
                end
                ACC_HI: begin
                    reload_d[CNT_W-1:BUS_W] = wdata_i;
                    commit = 1'b1;
                    if (am_q == AM_LOHI) acc_d = ACC_LO;
                end
                default: ;
            endcase
        end

        if (commit && !(is_rate && run_q == RUN_ACTIVE)) begin
            run_d = RUN_PEND;
            if (is_level) out_d = 1'b0;
        end

        if (cmd_i) begin
            if (amode_e'(cmd_acc_i) == AM_LATCH) begin
                if (!lat_v_q) begin
                    lat_d   = cnt_q;
                    lat_v_d = 1'b1;
                end
            end else begin
                am_d    = amode_e'(cmd_acc_i);
                om_d    = new_mode;
                acc_d   = (amode_e'(cmd_acc_i) == AM_HI) ? ACC_HI : ACC_LO;
                run_d   = RUN_IDLE;
                rd_hi_d = 1'b0;
                out_d   = !((new_mode == OM_TERM) || (new_mode == OM_ONESHOT));
            end
        end
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= RUN_IDLE;
            acc_q    <= ACC_NONE;
            am_q     <= AM_LATCH;
            om_q     <= OM_TERM;
            reload_q <= '0;
            cnt_q    <= '0;
            lat_q    <= '0;
            lat_v_q  <= 1'b0;
            rd_hi_q  <= 1'b0;
            out_q    <= 1'b0;
        end else begin
            run_q    <= run_d;
            acc_q    <= acc_d;
            am_q     <= am_d;
            om_q     <= om_d;
            reload_q <= reload_d;
            cnt_q    <= cnt_d;
            lat_q    <= lat_d;
            lat_v_q  <= lat_v_d;
            rd_hi_q  <= rd_hi_d;
            out_q    <= out_d;
        end
    end

    // output process
    always_comb begin
        rd_src  = lat_v_q ? lat_q : cnt_q;
        rdata_o = rd_hi_q ? rd_src[CNT_W-1:BUS_W] : rd_src[BUS_W-1:0];
        out_o   = out_q;
    end

    p_pend_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q == RUN_PEND && tick_i && !cmd_i && !wr_i)
        |=> (run_q == RUN_ACTIVE && cnt_q == $past(reload_eff)));

    p_sq_even_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q == RUN_ACTIVE && om_q == OM_SQUARE) |-> !cnt_q[0]);

    p_latch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_v_q && !(rd_i && rd_hi_q)) |=> (lat_v_q && $stable(lat_q)));

    p_level_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q == RUN_ACTIVE && is_level && out_q && !cmd_i && !wr_i) |=> out_q);

    p_idle_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q == RUN_IDLE) |=> $stable(cnt_q));

endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
#(
    parameter int N_CH     = 3,
    parameter int BUS_W    = 8,
    parameter int GATED_CH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [1:0]       bus_addr,
    input  logic             bus_spk,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    output logic [N_CH-1:0]  tmr_out,
    output logic             irq
);
    localparam int ADDR_W   = 2;
    localparam int GATE_BIT = 0;
    localparam int ECHO_BIT = 5;

    logic [N_CH-1:0]  data_wr, data_rd, cmd_wr, ch_tick;
    logic             spk_wr;
    logic [BUS_W-1:0] spk_q;
    logic [BUS_W-1:0] ch_rdata [N_CH];

    pit_bus_decode #(.N_CH(N_CH), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_dec (
        .addr_i    (bus_addr),
        .spk_i     (bus_spk),
        .wr_i      (bus_wr),
        .rd_i      (bus_rd),
        .wdata_i   (bus_wdata),
        .data_wr_o (data_wr),
        .data_rd_o (data_rd),
        .cmd_wr_o  (cmd_wr),
        .spk_wr_o  (spk_wr)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        if (i == GATED_CH) begin : g_gated
            assign ch_tick[i] = tick && spk_q[GATE_BIT];
        end else begin : g_free
            assign ch_tick[i] = tick;
        end

        pit_channel #(.BUS_W(BUS_W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick_i     (ch_tick[i]),
            .cmd_i      (cmd_wr[i]),
            .cmd_acc_i  (bus_wdata[5:4]),
            .cmd_mode_i (bus_wdata[3:1]),
            .wr_i       (data_wr[i]),
            .rd_i       (data_rd[i]),
            .wdata_i    (bus_wdata),
            .rdata_o    (ch_rdata[i]),
            .out_o      (tmr_out[i])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spk_q <= '0;
        end else if (spk_wr) begin
            spk_q           <= bus_wdata;
            spk_q[ECHO_BIT] <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_spk) begin
            bus_rdata = spk_q;
            bus_rdata[ECHO_BIT] = spk_q[GATE_BIT] && tmr_out[GATED_CH];
        end else begin
            for (int k = 0; k < N_CH; k++) begin
                if (bus_addr == ADDR_W'(k)) bus_rdata = ch_rdata[k];
            end
        end
    end

    assign irq = tmr_out[0];

    p_echo_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_spk && bus_wr) |=> !spk_q[ECHO_BIT]);

endmodule

// File: tb/pit_timer_tb_top.sv
`timescale 1ns/100ps
module pit_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_spk = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [2:0] tmr_out;
    logic       irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pit_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
        .bus_spk(bus_spk), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tmr_out(tmr_out), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic s, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_spk = s; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_spk = 1'b0;
    endtask

    task automatic bread(input logic s, input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_spk = s; bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_spk = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic rd16(input logic [1:0] ch, output int v);
        logic [7:0] lo, hi;
        bread(1'b0, ch, lo);
        bread(1'b0, ch, hi);
        v = {hi, lo};
    endtask

    task automatic prog(input logic [1:0] ch, input logic [2:0] mode, input int n);
        bwrite(1'b0, 2'd3, {ch, 2'b11, mode, 1'b0});
        bwrite(1'b0, ch, n[7:0]);
        bwrite(1'b0, ch, n[15:8]);
    endtask

    // model: effective period, count and terminal-count number after t ticks since commit
    function automatic int eff_len(input int mode, input int n);
        int l = (mode == 3) ? (n & 16'hFFFE) : n;
        return (l == 0) ? 65536 : l;
    endfunction

    function automatic int exp_cnt(input int mode, input int n, input int t);
        int s = (mode == 3) ? 2 : 1;
        int l = eff_len(mode, n);
        return (l - (((t - 1) * s) % l)) & 16'hFFFF;
    endfunction

    function automatic int exp_tcs(input int mode, input int n, input int t);
        int s = (mode == 3) ? 2 : 1;
        return ((t - 1) * s) / eff_len(mode, n);
    endfunction

    function automatic int exp_out(input int mode, input int n, input int t);
        int s = (mode == 3) ? 2 : 1;
        case (mode)
            0, 1:    return (exp_tcs(mode, n, t) > 0) ? 1 : 0;
            2:       return (t > 1 && (((t - 1) * s) % eff_len(mode, n)) == 0) ? 0 : 1;
            default: return 1 ^ (exp_tcs(mode, n, t) & 1);
        endcase
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        int v;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 outputs", int'(tmr_out), 0);
        chk("R1 irq", int'(irq), 0);
        bread(1'b1, 2'd0, b); chk("R1 speaker", int'(b), 0);
        rd16(2'd0, v); chk("R1/R4 count ch0", v, 0);

        // R5 data write before any control word ignored
        bwrite(1'b0, 2'd1, 8'h55);
        ticks(3);
        rd16(2'd1, v); chk("R5 write before control ignored", v, 0);

        // R12 gating of channel 2
        prog(2'd2, 3'd0, 5);
        ticks(4);
        rd16(2'd2, v); chk("R12 gate off holds ch2", v, 0);
        bwrite(1'b1, 2'd0, 8'hFF);
        bread(1'b1, 2'd0, b); chk("R12 read out2 low", int'(b), 8'hDF);
        ticks(1);
        rd16(2'd2, v); chk("R12 gate on loads ch2", v, 5);
        bwrite(1'b0, 2'd3, 8'hB4); // ch2 mode 2, output high
        bread(1'b1, 2'd0, b); chk("R12 read out2 high", int'(b), 8'hFF);
        bwrite(1'b1, 2'd0, 8'hFE);
        bread(1'b1, 2'd0, b); chk("R12 gate off masks bit5", int'(b), 8'hDE);
        bwrite(1'b1, 2'd0, 8'h01);

        // R5 low-only then high-only access, R7 change only on tick
        bwrite(1'b0, 2'd3, 8'h50);
        bwrite(1'b0, 2'd1, 8'h34);
        ticks(1);
        bread(1'b0, 2'd1, b); chk("R5 low-only low byte", int'(b), 8'h34);
        bread(1'b0, 2'd1, b); chk("R5 low-only high byte", int'(b), 8'h00);
        bwrite(1'b0, 2'd3, 8'h60);
        bwrite(1'b0, 2'd1, 8'h12);
        rd16(2'd1, v); chk("R7 no load before tick", v, 16'h0034);
        ticks(1);
        rd16(2'd1, v); chk("R5 high-only keeps low byte", v, 16'h1234);

        // R3/R4 latching
        prog(2'd0, 3'd2, 100);
        ticks(5);
        bwrite(1'b0, 2'd3, 8'h00);
        ticks(3);
        bwrite(1'b0, 2'd3, 8'h00);
        ticks(2);
        rd16(2'd0, v); chk("R3 latched value, second latch ignored", v, 96);
        rd16(2'd0, v); chk("R4 high read released latch", v, 91);
        chk("R13 irq follows out0", int'(irq), int'(tmr_out[0]));
        bread(1'b0, 2'd3, b); chk("R4 control port reads zero", int'(b), 0);

        // R6/R9 rate generator rewrite while running
        prog(2'd0, 3'd2, 10);
        ticks(4);
        bwrite(1'b0, 2'd0, 8'd20);
        bwrite(1'b0, 2'd0, 8'd0);
        ticks(1);
        rd16(2'd0, v); chk("R6 running rate keeps counting", v, 6);
        ticks(5);
        rd16(2'd0, v); chk("R6 count before wrap", v, 1);
        ticks(1);
        rd16(2'd0, v); chk("R6 new reload at wrap", v, 20);
        chk("R9 out low at terminal count", int'(tmr_out[0]), 0);
        chk("R13 irq low with out0", int'(irq), 0);
        ticks(1);
        chk("R9 out high after one tick", int'(tmr_out[0]), 1);
        rd16(2'd0, v); chk("R9 count after reload", v, 19);

        // R8 mode 0 terminal count
        prog(2'd1, 3'd0, 3);
        chk("R8 out low after commit", int'(tmr_out[1]), 0);
        ticks(3);
        chk("R8 out low before terminal count", int'(tmr_out[1]), 0);
        ticks(1);
        chk("R8 out high at terminal count", int'(tmr_out[1]), 1);
        rd16(2'd1, v); chk("R8 reload at terminal count", v, 3);
        ticks(3);
        chk("R8 out stays high", int'(tmr_out[1]), 1);

        // R11 software strobe
        prog(2'd1, 3'd4, 3);
        chk("R2 out high for mode 4", int'(tmr_out[1]), 1);
        ticks(4);
        chk("R11 strobe low", int'(tmr_out[1]), 0);
        ticks(1);
        chk("R11 strobe ends", int'(tmr_out[1]), 1);
        ticks(5);
        rd16(2'd1, v); chk("R11 stopped after strobe", v, 3);

        // R2 alias mode 7 = square, R10 even count
        prog(2'd1, 3'd7, 7);
        ticks(2);
        rd16(2'd1, v); chk("R2/R10 mode 7 as square, even", v, 4);
        bwrite(1'b0, 2'd3, 8'hFE);
        ticks(1);
        rd16(2'd1, v); chk("R2 channel field 3 ignored", v, 2);
        ticks(1);
        chk("R10 toggle at terminal count", int'(tmr_out[1]), 0);

        // R7 zero means 65536
        prog(2'd1, 3'd0, 0);
        ticks(1);
        rd16(2'd1, v); chk("R7 zero load", v, 0);
        ticks(1);
        rd16(2'd1, v); chk("R7 zero wraps to 65535", v, 16'hFFFF);
        chk("R7/R8 no terminal count yet", int'(tmr_out[1]), 0);

        // random mix
        for (int it = 0; it < 24; it++) begin
            int ch = $urandom % 3;
            int md = $urandom % 4;
            int n  = 2 + ($urandom % 60);
            int t  = 1 + ($urandom % 150);
            prog(2'(ch), 3'(md), n);
            ticks(t);
            rd16(2'(ch), v);
            chk((md == 3) ? "R10 random count" : "R7 random count", v, exp_cnt(md, n, t));
            chk((md == 2) ? "R9 random out" : (md == 3) ? "R10 random out" : "R8 random out",
                int'(tmr_out[ch]), exp_out(md, n, t));
            if (ch == 0) chk("R13 random irq", int'(irq), exp_out(md, n, t));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule